// File: doc/BRIEF.md
# Masked Operand Address Generator

This block produces the memory operand address for multiply-accumulate instructions. It holds a file of address registers and a software-visible mask register. Each request names one address register, an addressing mode, a 16-bit displacement and a mask-enable flag. The block computes the operand address combinationally from the current register contents. In the auto-update modes it also writes the new register value back at the next rising clock edge.

When mask-enable is set, both the operand address and any written-back register value are ANDed with an effective mask. The effective mask is all ones in the upper half and the mask register's low field in the lower half. Clearing low mask bits confines a post-incrementing pointer to a power-of-two aligned window, so an ordinary address register becomes a circular queue pointer. A separate write port loads the address registers. The mask register has its own write port and a read port.

Top module: `maddr_gen`

## Requirements
- R1: A synchronous active-high reset clears every address register to zero and makes the mask register read 0xFFFFFFFF.
- R2: The upper 16 bits of the mask register always read as ones and ignore writes. The lower 16 bits take the written value at the next clock edge.
- R3: With the request's mask-enable clear, no AND is applied: the operand address is the unmasked mode result.
- R4: Mode code 0 (indirect): the operand address is the register ANDed with the effective mask {0xFFFF, mask[15:0]}, and the register keeps its value.
- R5: Mode code 1 (post-increment): the operand address is the masked register, and the register becomes (register + 4) ANDed with the effective mask.
- R6: Mode code 2 (pre-decrement): the operand address and the new register value both equal (register - 4) ANDed with the effective mask.
- R7: Mode code 3 (displacement): the 16-bit displacement is sign-extended, added to the register, then masked. The register keeps its value.
- R8: All additions and subtractions wrap modulo 2^32.
- R9: If a register-port write and an auto-update target the same register in one cycle, the auto-update value is stored. A register-port write to a different register in that cycle still lands.
- R10: Register write-back happens only when the request-valid strobe is high. With it low, the operand address is still produced but no register changes.
- R11: With mask-enable set and a mask of 0xFFFFFF0F, repeated post-increments visit the four word addresses of a 16-byte aligned window and then return to its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; enables write-back |
| req_idx | input | 3 | Address register selected by the request |
| req_mode | input | 2 | Addressing mode: 0 indirect, 1 post-increment, 2 pre-decrement, 3 displacement |
| req_disp | input | 16 | Signed displacement for mode 3 |
| req_mask_en | input | 1 | Apply the effective mask when high |
| op_addr | output | 32 | Combinational operand address |
| mask_wr_en | input | 1 | Mask register write strobe |
| mask_wr_data | input | 32 | Mask write value (upper half ignored) |
| mask_rd_data | output | 32 | Current mask register value |
| reg_wr_en | input | 1 | Address register load strobe |
| reg_wr_idx | input | 3 | Address register to load |
| reg_wr_data | input | 32 | Load value |

## Verification
The checker expects reset to be high from time zero and held for at least one clock. The mode input must hold one of the four defined codes whenever the request strobe is high. The bench raises reset before the first edge and keeps it for several cycles. It drives every request from a task that only issues the four mode codes and keeps all inputs stable across each clock edge. Register contents are read back by issuing an unstrobed indirect request with masking off, which cannot disturb any state.

// File: rtl/maddr_pkg.sv
package maddr_pkg;

  typedef enum logic [1:0] {
    AM_IND     = 2'd0,
    AM_POSTINC = 2'd1,
    AM_PREDEC  = 2'd2,
    AM_DISP    = 2'd3
  } am_mode_e;

  function automatic logic mode_is_auto(input am_mode_e m);
    return (m == AM_POSTINC) || (m == AM_PREDEC);
  endfunction

endpackage

// File: rtl/maddr_mask_reg.sv
module maddr_mask_reg #(
  parameter int AW = 32,
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] mask_q
);

  localparam int HW = AW - MW;

  logic [AW-1:0] forced_ones;

  generate
    if (HW > 0) begin : g_upper
      assign forced_ones = {{HW{1'b1}}, {MW{1'b0}}};
    end else begin : g_full
      assign forced_ones = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (wr_en) begin
      mask_q <= wr_data | forced_ones;
    end
  end

endmodule

// File: rtl/maddr_regfile.sv
module maddr_regfile #(
  parameter int AW   = 32,
  parameter int NREG = 8,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_idx,
  input  logic [AW-1:0] upd_data,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_data
);

  logic [AW-1:0] regs [NREG];

  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_ent
      logic hit_upd;
      logic hit_wr;
      assign hit_upd = upd_en && (upd_idx == IW'(gi));
      assign hit_wr  = wr_en  && (wr_idx  == IW'(gi));

      always_ff @(posedge clk) begin
        if (rst) begin
          regs[gi] <= '0;
        end else if (hit_upd) begin
          regs[gi] <= upd_data;
        end else if (hit_wr) begin
          regs[gi] <= wr_data;
        end
      end
    end
  endgenerate

  assign rd_data = regs[rd_idx];

endmodule

// File: rtl/maddr_calc.sv
module maddr_calc
  import maddr_pkg::*;
#(
  parameter int AW     = 32,
  parameter int MW     = 16,
  parameter int DISP_W = 16,
  parameter int STEP   = 4
) (
  input  logic [AW-1:0]     base,
  input  am_mode_e          mode,
  input  logic [DISP_W-1:0] disp,
  input  logic              mask_en,
  input  logic [AW-1:0]     mask_reg,
  output logic [AW-1:0]     eff_mask,
  output logic [AW-1:0]     addr,
  output logic              auto_upd,
  output logic [AW-1:0]     new_val
);

  localparam int HW = AW - MW;
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  function automatic logic [AW-1:0] sext(input logic [DISP_W-1:0] d);
    return {{(AW-DISP_W){d[DISP_W-1]}}, d};
  endfunction

  function automatic logic [AW-1:0] build_mask(input logic en, input logic [AW-1:0] m);
    logic [AW-1:0] r;
    r = '1;
    if (en) r[MW-1:0] = m[MW-1:0];
    return r;
  endfunction

  logic [AW-1:0] plus_step;
  logic [AW-1:0] minus_step;
  logic [AW-1:0] plus_disp;
  logic [AW-1:0] raw_addr;
  logic [AW-1:0] raw_new;

  assign eff_mask   = build_mask(mask_en, mask_reg);
  assign plus_step  = base + STEP_V;
  assign minus_step = base - STEP_V;
  assign plus_disp  = base + sext(disp);

  always_comb begin
    raw_addr = base;
    raw_new  = base;
    unique case (mode)
      AM_IND:     begin raw_addr = base;       raw_new = base;       end
      AM_POSTINC: begin raw_addr = base;       raw_new = plus_step;  end
      AM_PREDEC:  begin raw_addr = minus_step; raw_new = minus_step; end
      AM_DISP:    begin raw_addr = plus_disp;  raw_new = base;       end
      default:    begin raw_addr = base;       raw_new = base;       end
    endcase
  end

  assign addr     = raw_addr & eff_mask;
  assign new_val  = raw_new & eff_mask;
  assign auto_upd = mode_is_auto(mode);

endmodule

// File: rtl/maddr_gen.sv
module maddr_gen
  import maddr_pkg::*;
#(
  parameter int AW     = 32,
  parameter int NREG   = 8,
  parameter int MW     = 16,
  parameter int DISP_W = 16,
  parameter int STEP   = 4,
  localparam int IW    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [IW-1:0]     req_idx,
  input  logic [1:0]        req_mode,
  input  logic [DISP_W-1:0] req_disp,
  input  logic              req_mask_en,
  output logic [AW-1:0]     op_addr,
  input  logic              mask_wr_en,
  input  logic [AW-1:0]     mask_wr_data,
  output logic [AW-1:0]     mask_rd_data,
  input  logic              reg_wr_en,
  input  logic [IW-1:0]     reg_wr_idx,
  input  logic [AW-1:0]     reg_wr_data
);

  am_mode_e      mode_q;
  logic [AW-1:0] base_val;
  logic [AW-1:0] mask_eff;
  logic          auto_mode;
  logic [AW-1:0] upd_data;
  logic          upd_en;

  assign mode_q = am_mode_e'(req_mode);

  maddr_mask_reg #(.AW(AW), .MW(MW)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (mask_wr_en),
    .wr_data (mask_wr_data),
    .mask_q  (mask_rd_data)
  );

  maddr_regfile #(.AW(AW), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr_en),
    .wr_idx   (reg_wr_idx),
    .wr_data  (reg_wr_data),
    .upd_en   (upd_en),
    .upd_idx  (req_idx),
    .upd_data (upd_data),
    .rd_idx   (req_idx),
    .rd_data  (base_val)
  );

  maddr_calc #(.AW(AW), .MW(MW), .DISP_W(DISP_W), .STEP(STEP)) u_calc (
    .base     (base_val),
    .mode     (mode_q),
    .disp     (req_disp),
    .mask_en  (req_mask_en),
    .mask_reg (mask_rd_data),
    .eff_mask (mask_eff),
    .addr     (op_addr),
    .auto_upd (auto_mode),
    .new_val  (upd_data)
  );

  assign upd_en = req_valid && auto_mode;

endmodule

// File: rtl/maddr_gen_chk.sv
module maddr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [1:0]    req_mode,
  input logic          req_mask_en,
  input logic [AW-1:0] op_addr,
  input logic [AW-1:0] mask_rd_data,
  input logic [AW-1:0] base_val,
  input logic [AW-1:0] mask_eff,
  input logic          upd_en,
  input logic [AW-1:0] upd_data
);

  AST_RESET_MASK: assert property (@(posedge clk) rst |=> mask_rd_data == '1); // R1
  AST_MASK_UPPER_ONES: assert property (@(posedge clk) disable iff (rst) mask_rd_data[AW-1:AW/2] == '1); // R2
  AST_UNMASKED_FULL: assert property (@(posedge clk) disable iff (rst) !req_mask_en |-> mask_eff == '1); // R3
  AST_IND_PASS: assert property (@(posedge clk) disable iff (rst) (req_mode == 2'd0 && !req_mask_en) |-> op_addr == base_val); // R4
  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (rst) req_mask_en |-> (op_addr & ~mask_eff) == '0); // R4
  AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (rst) (upd_en && req_mode == 2'd1 && !req_mask_en) |-> upd_data == op_addr + 32'd4); // R5
  AST_PREDEC_MATCH: assert property (@(posedge clk) disable iff (rst) (upd_en && req_mode == 2'd2) |-> upd_data == op_addr); // R6
  AST_NO_UPD_STATIC: assert property (@(posedge clk) disable iff (rst) (req_mode == 2'd0 || req_mode == 2'd3) |-> !upd_en); // R7
  AST_NO_UPD_IDLE: assert property (@(posedge clk) disable iff (rst) !req_valid |-> !upd_en); // R10

endmodule

bind maddr_gen maddr_gen_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_mode     (req_mode),
  .req_mask_en  (req_mask_en),
  .op_addr      (op_addr),
  .mask_rd_data (mask_rd_data),
  .base_val     (base_val),
  .mask_eff     (mask_eff),
  .upd_en       (upd_en),
  .upd_data     (upd_data)
);

// File: tb/sim_maddr_gen.sv
`timescale 1ns/1ps
module sim_maddr_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_idx = '0;
  logic [1:0]  req_mode = '0;
  logic [15:0] req_disp = '0;
  logic        req_mask_en = 1'b0;
  logic [31:0] op_addr;
  logic        mask_wr_en = 1'b0;
  logic [31:0] mask_wr_data = '0;
  logic [31:0] mask_rd_data;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_idx = '0;
  logic [31:0] reg_wr_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_regs [8];
  logic [31:0] m_mask;

  logic [31:0] q_exp [$];
  bit          q_kind [$];
  string       q_tag [$];

  always #2 clk = ~clk;

  maddr_gen u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_idx(req_idx),
    .req_mode(req_mode), .req_disp(req_disp), .req_mask_en(req_mask_en),
    .op_addr(op_addr), .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .mask_rd_data(mask_rd_data), .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx),
    .reg_wr_data(reg_wr_data)
  );

  // monitor: compares one queued expectation per cycle, mid-cycle
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      logic [31:0] e;
      logic [31:0] a;
      bit k;
      string t;
      e = q_exp.pop_front();
      k = q_kind.pop_front();
      t = q_tag.pop_front();
      a = k ? mask_rd_data : op_addr;
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: %s actual=%h expected=%h", t, k ? "mask" : "addr", a, e);
      end
    end
  end

  function automatic logic [31:0] m_eff(input bit men);
    return men ? {16'hFFFF, m_mask[15:0]} : 32'hFFFF_FFFF;
  endfunction

  task automatic push(input bit kind, input logic [31:0] e, input string tag);
    q_exp.push_back(e);
    q_kind.push_back(kind);
    q_tag.push_back(tag);
  endtask

  task automatic go_idle();
    req_valid = 0; req_mode = 0; req_mask_en = 0; req_disp = 0;
    mask_wr_en = 0; reg_wr_en = 0;
  endtask

  task automatic drive_req(input int idx, input logic [1:0] mode, input logic [15:0] disp,
                           input bit men, input bit valid, input string tag,
                           input bit xwr = 0, input int widx = 0, input logic [31:0] wdata = 0);
    logic [31:0] b, em, a, nv;
    bit autom;
    b = m_regs[idx];
    em = m_eff(men);
    autom = 0;
    nv = b;
    case (mode)
      2'd0: a = b & em;
      2'd1: begin a = b & em; nv = (b + 32'd4) & em; autom = 1; end
      2'd2: begin a = (b - 32'd4) & em; nv = a; autom = 1; end
      default: a = (b + {{16{disp[15]}}, disp}) & em;
    endcase
    req_valid = valid; req_idx = 3'(idx); req_mode = mode; req_disp = disp; req_mask_en = men;
    reg_wr_en = xwr; reg_wr_idx = 3'(widx); reg_wr_data = wdata;
    push(0, a, tag);
    @(posedge clk); #1;
    if (xwr) m_regs[widx] = wdata;
    if (valid && autom) m_regs[idx] = nv;
    go_idle();
  endtask

  task automatic peek(input int idx, input string tag);
    drive_req(idx, 2'd0, 16'h0, 0, 0, tag);
  endtask

  task automatic load(input int idx, input logic [31:0] v);
    reg_wr_en = 1; reg_wr_idx = 3'(idx); reg_wr_data = v;
    @(posedge clk); #1;
    m_regs[idx] = v;
    go_idle();
  endtask

  task automatic set_mask(input logic [31:0] v);
    mask_wr_en = 1; mask_wr_data = v;
    @(posedge clk); #1;
    m_mask = v | 32'hFFFF_0000;
    go_idle();
  endtask

  task automatic check_mask(input string tag);
    push(1, m_mask, tag);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_regs[i] = '0;
    m_mask = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1 rst = 0;

    check_mask("R1");
    for (int i = 0; i < 8; i++) peek(i, "R1");

    set_mask(32'h1234_FF0F);
    check_mask("R2");

    load(0, 32'h1000_0034);
    load(1, 32'h2000_0100);
    load(2, 32'hFFFF_FFFE);
    load(3, 32'h0000_0002);

    drive_req(0, 2'd0, 16'h0, 0, 1, "R3");
    drive_req(0, 2'd0, 16'h0, 1, 1, "R4");
    peek(0, "R4");

    for (int i = 0; i < 5; i++) drive_req(1, 2'd1, 16'h0, 1, 1, "R11");
    peek(1, "R5");

    drive_req(3, 2'd2, 16'h0, 0, 1, "R8");
    peek(3, "R6");
    drive_req(0, 2'd2, 16'h0, 1, 1, "R6");
    peek(0, "R6");

    drive_req(1, 2'd3, 16'hFFF0, 0, 1, "R7");
    drive_req(1, 2'd3, 16'h0123, 1, 1, "R7");
    peek(1, "R7");

    drive_req(2, 2'd1, 16'h0, 0, 1, "R8");
    peek(2, "R8");
    drive_req(2, 2'd1, 16'h0, 0, 1, "R5");
    peek(2, "R5");

    drive_req(1, 2'd1, 16'h0, 1, 0, "R10");
    peek(1, "R10");
    drive_req(3, 2'd2, 16'h0, 0, 0, "R10");
    peek(3, "R10");

    drive_req(3, 2'd1, 16'h0, 0, 1, "R9", 1, 3, 32'hDEAD_0000);
    peek(3, "R9");
    drive_req(3, 2'd1, 16'h0, 0, 1, "R9", 1, 4, 32'h0BAD_F00D);
    peek(3, "R9");
    peek(4, "R9");

    set_mask(32'h0000_00F0);
    check_mask("R2");
    drive_req(4, 2'd3, 16'h0004, 1, 1, "R7");

    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule